// File: doc/BRIEF.md
# Supervised Memory Access Controller

This block fronts a small word memory in which every data word carries a separate metadata tag, and both are selected by the same address. A requester issues one access at a time over a valid/ready port. An access is either plain or supervised. A plain access moves data only: it leaves the tag untouched and can never fault.

A supervised access first reads the tag of the addressed word. It then looks up a software-programmed transition table, indexed by the access kind and the current tag. Each table entry holds either a fault flag or a next tag value. On a fault, the access is vetoed. No data or tag changes, the response is flagged, and a fault record holding the address and access kind is raised toward a handler. The record stays up until the handler acknowledges it. Otherwise the tag moves to the next value and the data is read or written. All of this happens in one execute cycle, so nothing can interleave with it.

Typical use is an empty/full scheme. A supervised load of an Empty word faults, and a supervised store turns Empty into Full. Other policies, such as uninitialised-read checking or ownership tracking, are loaded through the configuration port.

Top module: `sup_mem_ctrl`

## Requirements
- R1: After reset, req_ready is 1 and rsp_valid and exc_valid are 0. Every word holds data 0 and tag 0.
- R2: A request is taken on a clock edge where req_valid and req_ready are both 1. req_ready is 0 in the following cycle. rsp_valid is 1 for exactly one cycle, starting two clock edges after acceptance.
- R3: A supervised access uses table entry index {is_store, tag}, where is_store is 1 for stores and tag is the 2-bit current tag. The entry is {fault, next_tag}. When fault is 0, the tag of the word becomes next_tag.
- R4: When a supervised access hits an entry with fault 1, the response has rsp_exc 1 and rsp_data 0. Neither data nor tag of the word changes.
- R5: A fault sets exc_valid, exc_addr and exc_is_store. These hold, and req_ready stays 0, until a cycle with exc_ack 1. After that cycle, exc_valid is 0.
- R6: Plain loads and plain stores never fault and leave the tag of the word unchanged.
- R7: A cycle with cfg_we 1 writes {cfg_fault, cfg_next} into table entry {cfg_is_store, cfg_state}. After reset, every entry is non-faulting and keeps the tag unchanged.
- R8: With an empty/full table (tag 0 Empty, tag 1 Full): a supervised load of an Empty word faults, and a supervised store to an Empty word makes it Full. A supervised store to a Full word faults, and a supervised load of a Full word returns its data.
- R9: A non-faulting load returns the stored data word in rsp_data. A non-faulting store writes req_wdata and returns rsp_data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Transition table write strobe |
| cfg_is_store | input | 1 | Table entry access kind (1 store) |
| cfg_state | input | META_W | Table entry current tag |
| cfg_fault | input | 1 | Entry fault flag |
| cfg_next | input | META_W | Entry next tag |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be taken |
| req_write | input | 1 | 1 store, 0 load |
| req_sup | input | 1 | 1 supervised, 0 plain |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Store data |
| rsp_valid | output | 1 | Response pulse |
| rsp_data | output | DATA_W | Load data |
| rsp_exc | output | 1 | Access was vetoed |
| exc_valid | output | 1 | Fault record pending |
| exc_addr | output | ADDR_W | Faulting address |
| exc_is_store | output | 1 | Faulting access kind |
| exc_ack | input | 1 | Handler acknowledge |

## Verification
The tag is never visible at the ports. Its value can only be inferred from whether a later supervised access faults under a known table. The bench therefore keeps its own tag and data image. It reprograms the whole table with many arithmetically generated policies, and runs interleaved plain and supervised sequences across all addresses. Every tag change or preserved tag is then revealed by a later fault or by its absence. Fault records are held for several cycles before acknowledgement, to show that they persist and block new requests.

// File: rtl/sup_mem_pkg.sv
package sup_mem_pkg;
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_EXEC = 1'b1
    } phase_e;
endpackage

// File: rtl/sup_meta_table.sv
module sup_meta_table #(
    parameter int META_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_op,
    input  logic [META_W-1:0] cfg_cur,
    input  logic              cfg_exc,
    input  logic [META_W-1:0] cfg_next,
    input  logic              lk_op,
    input  logic [META_W-1:0] lk_cur,
    output logic              lk_exc,
    output logic [META_W-1:0] lk_next
);
    localparam int IDX_W = META_W + 1;
    localparam int N_ENT = 2 ** IDX_W;

    logic [META_W:0] tbl_q [N_ENT];
    logic [META_W:0] tbl_d [N_ENT];

    always_comb begin
        for (int i = 0; i < N_ENT; i++) tbl_d[i] = tbl_q[i];
        if (cfg_we) tbl_d[{cfg_op, cfg_cur}] = {cfg_exc, cfg_next};
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < N_ENT; i++) begin
            if (!rst_n) tbl_q[i] <= {1'b0, META_W'(i)};
            else        tbl_q[i] <= tbl_d[i];
        end
    end

    logic [META_W:0] hit;
    assign hit     = tbl_q[{lk_op, lk_cur}];
    assign lk_exc  = hit[META_W];
    assign lk_next = hit[META_W-1:0];
endmodule

// File: rtl/sup_word_store.sv
module sup_word_store #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8,
    parameter int META_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [META_W-1:0] rd_meta,
    input  logic              wr_data_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_meta_en,
    input  logic [META_W-1:0] wr_meta
);
    localparam int DEPTH = 2 ** ADDR_W;

    logic [DATA_W-1:0] data_q [DEPTH];
    logic [DATA_W-1:0] data_d [DEPTH];
    logic [META_W-1:0] meta_q [DEPTH];
    logic [META_W-1:0] meta_d [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            data_d[i] = data_q[i];
            meta_d[i] = meta_q[i];
        end
        if (wr_data_en) data_d[addr] = wr_data;
        if (wr_meta_en) meta_d[addr] = wr_meta;
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n) begin
                data_q[i] <= '0;
                meta_q[i] <= '0;
            end else begin
                data_q[i] <= data_d[i];
                meta_q[i] <= meta_d[i];
            end
        end
    end

    assign rd_data = data_q[addr];
    assign rd_meta = meta_q[addr];
endmodule

// File: rtl/sup_mem_ctrl.sv
module sup_mem_ctrl #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8,
    parameter int META_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_is_store,
    input  logic [META_W-1:0] cfg_state,
    input  logic              cfg_fault,
    input  logic [META_W-1:0] cfg_next,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic              req_sup,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_exc,
    output logic              exc_valid,
    output logic [ADDR_W-1:0] exc_addr,
    output logic              exc_is_store,
    input  logic              exc_ack
);
    import sup_mem_pkg::*;

    typedef struct packed {
        phase_e            phase;
        logic              op_write;
        logic              op_sup;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              rsp_valid;
        logic [DATA_W-1:0] rsp_data;
        logic              rsp_exc;
        logic              exc_valid;
        logic [ADDR_W-1:0] exc_addr;
        logic              exc_is_store;
    } ctrl_t;

    ctrl_t st_q, st_d;

    logic [DATA_W-1:0] mem_data;
    logic [META_W-1:0] mem_meta;
    logic              tbl_exc;
    logic [META_W-1:0] tbl_next;
    logic              wr_data_en;
    logic              wr_meta_en;
    logic              ready_int;

    sup_meta_table #(.META_W(META_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_op   (cfg_is_store),
        .cfg_cur  (cfg_state),
        .cfg_exc  (cfg_fault),
        .cfg_next (cfg_next),
        .lk_op    (st_q.op_write),
        .lk_cur   (mem_meta),
        .lk_exc   (tbl_exc),
        .lk_next  (tbl_next)
    );

    sup_word_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .META_W(META_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr       (st_q.addr),
        .rd_data    (mem_data),
        .rd_meta    (mem_meta),
        .wr_data_en (wr_data_en),
        .wr_data    (st_q.wdata),
        .wr_meta_en (wr_meta_en),
        .wr_meta    (tbl_next)
    );

    always_comb begin
        st_d       = st_q;
        wr_data_en = 1'b0;
        wr_meta_en = 1'b0;
        ready_int  = (st_q.phase == PH_IDLE) && !st_q.exc_valid;
        st_d.rsp_valid = 1'b0;

        if (st_q.exc_valid && exc_ack) st_d.exc_valid = 1'b0;

        case (st_q.phase)
            PH_IDLE: begin
                if (req_valid && ready_int) begin
                    st_d.phase    = PH_EXEC;
                    st_d.op_write = req_write;
                    st_d.op_sup   = req_sup;
                    st_d.addr     = req_addr;
                    st_d.wdata    = req_wdata;
                end
            end
            PH_EXEC: begin
                st_d.phase     = PH_IDLE;
                st_d.rsp_valid = 1'b1;
                st_d.rsp_exc   = 1'b0;
                st_d.rsp_data  = '0;
                if (st_q.op_sup && tbl_exc) begin
                    st_d.rsp_exc      = 1'b1;
                    st_d.exc_valid    = 1'b1;
                    st_d.exc_addr     = st_q.addr;
                    st_d.exc_is_store = st_q.op_write;
                end else begin
                    wr_meta_en = st_q.op_sup && (tbl_next != mem_meta);
                    wr_data_en = st_q.op_write;
                    if (!st_q.op_write) st_d.rsp_data = mem_data;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.phase <= PH_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_ready    = ready_int;
    assign rsp_valid    = st_q.rsp_valid;
    assign rsp_data     = st_q.rsp_data;
    assign rsp_exc      = st_q.rsp_exc;
    assign exc_valid    = st_q.exc_valid;
    assign exc_addr     = st_q.exc_addr;
    assign exc_is_store = st_q.exc_is_store;
endmodule

// File: rtl/sup_mem_ctrl_chk.sv
module sup_mem_ctrl_chk #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              rsp_exc,
    input logic [DATA_W-1:0] rsp_data,
    input logic              exc_valid,
    input logic              exc_ack,
    input logic [ADDR_W-1:0] exc_addr,
    input logic              exc_is_store
);
    // R2
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R2
    rsp_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |-> ##2 rsp_valid);

    // R2
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R4
    veto_record_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_exc) |-> (exc_valid && rsp_data == '0));

    // R5
    fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid && !exc_ack) |=> (exc_valid && $stable(exc_addr) && $stable(exc_is_store)));

    // R5
    fault_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |-> !req_ready);

    // R5
    fault_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid && exc_ack) |=> !exc_valid);
endmodule

bind sup_mem_ctrl sup_mem_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .rsp_valid    (rsp_valid),
    .rsp_exc      (rsp_exc),
    .rsp_data     (rsp_data),
    .exc_valid    (exc_valid),
    .exc_ack      (exc_ack),
    .exc_addr     (exc_addr),
    .exc_is_store (exc_is_store)
);

// File: tb/test_sup_mem_ctrl.sv
`timescale 1ns/1ps
module test_sup_mem_ctrl;
    localparam int AW = 4;
    localparam int DW = 8;
    localparam int MW = 2;
    localparam int DEPTH = 2 ** AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic          cfg_is_store = 1'b0;
    logic [MW-1:0] cfg_state = '0;
    logic          cfg_fault = 1'b0;
    logic [MW-1:0] cfg_next = '0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic          req_sup = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          rsp_valid;
    logic [DW-1:0] rsp_data;
    logic          rsp_exc;
    logic          exc_valid;
    logic [AW-1:0] exc_addr;
    logic          exc_is_store;
    logic          exc_ack = 1'b0;

    always #4 clk = ~clk;

    sup_mem_ctrl #(.ADDR_W(AW), .DATA_W(DW), .META_W(MW)) i_sup_mem_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_is_store(cfg_is_store), .cfg_state(cfg_state),
        .cfg_fault(cfg_fault), .cfg_next(cfg_next),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_sup(req_sup), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_exc(rsp_exc),
        .exc_valid(exc_valid), .exc_addr(exc_addr), .exc_is_store(exc_is_store),
        .exc_ack(exc_ack)
    );

    int n_tests = 0;
    int n_fail  = 0;

    logic [MW:0]   m_tbl  [2*(2**MW)];
    logic [DW-1:0] m_data [DEPTH];
    logic [MW-1:0] m_meta [DEPTH];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic cfg_write(input bit is_st, input int cur, input bit flt, input int nxt);
        @(negedge clk);
        cfg_we       = 1'b1;
        cfg_is_store = is_st;
        cfg_state    = MW'(cur);
        cfg_fault    = flt;
        cfg_next     = MW'(nxt);
        @(negedge clk);
        cfg_we = 1'b0;
        m_tbl[{is_st, MW'(cur)}] = {flt, MW'(nxt)};
    endtask

    task automatic access(input bit wr, input bit sup, input int a,
                          input logic [DW-1:0] wd, input string req);
        logic [MW:0]   ent;
        bit            exp_exc;
        logic [DW-1:0] exp_data;
        ent      = m_tbl[{wr, m_meta[a]}];
        exp_exc  = sup && ent[MW];
        exp_data = (!exp_exc && !wr) ? m_data[a] : '0;
        @(negedge clk);
        for (int w = 0; w < 10 && !req_ready; w++) @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_sup   = sup;
        req_addr  = AW'(a);
        req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R2", "ready after accept", 32'(req_ready), 0);
        @(negedge clk);
        chk(rsp_valid == 1'b1, "R2", "rsp_valid timing", 32'(rsp_valid), 1);
        chk(rsp_exc == exp_exc, req, "rsp_exc", 32'(rsp_exc), 32'(exp_exc));
        chk(rsp_data == exp_data, req, "rsp_data", 32'(rsp_data), 32'(exp_data));
        if (exp_exc) begin
            chk(exc_valid && exc_addr == AW'(a) && exc_is_store == wr, "R5", "fault record",
                {exc_valid, exc_is_store, 26'(exc_addr)}, {2'b11 & {1'b1, wr}, 26'(a)});
            @(negedge clk);
            chk(rsp_valid == 1'b0, "R2", "rsp pulse width", 32'(rsp_valid), 0);
            chk(exc_valid && !req_ready && exc_addr == AW'(a), "R5", "fault held",
                {exc_valid, req_ready}, 2'b10);
            exc_ack = 1'b1;
            @(negedge clk);
            exc_ack = 1'b0;
            chk(!exc_valid && req_ready, "R5", "fault cleared",
                {exc_valid, req_ready}, 2'b01);
        end else begin
            if (sup) m_meta[a] = ent[MW-1:0];
            if (wr)  m_data[a] = wd;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog run did not complete");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 2*(2**MW); i++) m_tbl[i] = {1'b0, MW'(i)};
        for (int i = 0; i < DEPTH; i++) begin
            m_data[i] = '0;
            m_meta[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(req_ready == 1'b1, "R1", "ready after reset", 32'(req_ready), 1);
        chk(rsp_valid == 1'b0 && exc_valid == 1'b0, "R1", "idle outputs",
            {rsp_valid, exc_valid}, 0);
        for (int a = 0; a < DEPTH; a++) access(1'b0, 1'b0, a, '0, "R1");

        // R7 default table: supervised ops never fault; R9 data path
        for (int a = 0; a < DEPTH; a++) access(1'b1, 1'b1, a, DW'(a * 13 + 5), "R7");
        for (int a = 0; a < DEPTH; a++) access(1'b0, 1'b1, a, '0, "R9");

        // R8 empty/full policy: tag 0 Empty, 1 Full, 2/3 fault
        for (int s = 0; s < 4; s++) begin
            cfg_write(1'b0, s, (s != 1), s);
            cfg_write(1'b1, s, (s != 0), 1);
        end
        for (int a = 0; a < DEPTH; a++) begin
            access(1'b0, 1'b1, a, '0, "R8");
            access(1'b1, 1'b0, a, DW'(a + 100), "R6");
            access(1'b0, 1'b1, a, '0, "R6");
            access(1'b1, 1'b1, a, DW'(a * 7 + 1), "R8");
            access(1'b0, 1'b0, a, '0, "R6");
            access(1'b1, 1'b1, a, DW'(8'hee), "R8");
            access(1'b0, 1'b1, a, '0, "R8");
            access(1'b1, 1'b0, a, DW'(a + 200), "R6");
            access(1'b1, 1'b1, a, DW'(8'h11), "R4");
            access(1'b0, 1'b1, a, '0, "R9");
        end

        // R3 generated policies, mixed plain and supervised sweeps
        for (int seed = 0; seed < 16; seed++) begin
            for (int idx = 0; idx < 8; idx++)
                cfg_write(idx[2], idx % 4, ((seed + idx) % 3 == 0), (seed + idx * 3) % 4);
            for (int k = 0; k < 48; k++) begin
                int a;
                int kind;
                a    = (k * 7 + seed) % DEPTH;
                kind = (k + seed) % 4;
                case (kind)
                    0: access(1'b0, 1'b1, a, '0, "R3");
                    1: access(1'b1, 1'b1, a, DW'(k * 37 + seed * 11), "R3");
                    2: access(1'b0, 1'b0, a, '0, "R6");
                    default: access(1'b1, 1'b0, a, DW'(k * 29 + seed), "R6");
                endcase
            end
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule